// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns the opening address of a bus burst into the address of each following beat. A bridge controller loads the start address, the 3-bit burst kind and the 3-bit transfer size with a one-cycle `load` pulse. The block shows the first beat address on the cycle after the load. Each later `step` pulse moves it on by one beat. The generator tracks the beat position for fixed-length bursts and marks the final beat with `last_beat`. It also warns with `bdry_cross` when an incrementing burst is about to leave its current 1 KB region. A start address that is not aligned to the transfer size, or a size wider than a word, sets `align_err` and keeps the generator from stepping.

All pins are plain control and status pins; there is no stream interface at the block's edge. The controller decides when to issue `step`, so back-pressure from a slow peripheral simply means fewer step pulses. For an undefined-length burst, the generator keeps advancing until the next `load`.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `beat_addr` is 0, and `active`, `last_beat`, `bdry_cross` and `align_err` are all 0.
- R2: A `load` pulse puts `start_addr` on `beat_addr` in the next cycle. If the start is accepted, `active` rises in that same cycle. `load` wins over a `step` in the same cycle.
- R3: In an incrementing burst, each accepted `step` adds the transfer size to `beat_addr`. The size codes are 000 = byte (+1), 001 = halfword (+2) and 010 = word (+4).
- R4: The wrapping kinds are 010 = WRAP4, 100 = WRAP8 and 110 = WRAP16. For a WRAPn burst the wrap block is n times the transfer size. The address bits below that block size increase modulo the block, and all higher bits stay unchanged.
- R5: The burst kinds 000 = SINGLE, 011 = INCR4, 101 = INCR8 and 111 = INCR16 give 1, 4, 8 and 16 beats. The wrapping kinds give 4, 8 and 16 beats. `last_beat` is high exactly while the final beat is presented.
- R6: A `step` on the final beat of a fixed-length burst drops `active` and leaves `beat_addr` on the final address.
- R7: Burst kind 001 (INCR, undefined length) never asserts `last_beat` and keeps stepping for as long as `step` pulses arrive.
- R8: `bdry_cross` is high while an incrementing burst that is not on its last beat has a next address that differs from the current one in bit 10 or above. It is always 0 for wrapping bursts.
- R9: A load is refused when the start address is misaligned (a halfword with bit 0 set, or a word with bits 1:0 not zero) or when the size code is 011 or above. A refused load sets `align_err` and leaves `active` at 0, so later steps leave `beat_addr` unchanged.
- R10: A `step` while `active` is 0 has no effect on `beat_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Start a new burst from the inputs below |
| start_addr | input | 32 | First beat address |
| burst_kind | input | 3 | Burst encoding (see R4, R5, R7) |
| xfer_size | input | 3 | Transfer size encoding (see R3) |
| step | input | 1 | Advance to the next beat |
| beat_addr | output | 32 | Current beat address |
| active | output | 1 | A burst is in progress and may step |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |
| bdry_cross | output | 1 | Next incrementing beat leaves the current 1 KB region |
| align_err | output | 1 | Last load was refused |

## Verification
The hardest case to reach from the ports is a wrap that happens inside a burst which also sits right next to a 1 KB edge. There, an incrementing calculation would cross the edge, while the correct wrapping one must not. The stimulus places a WRAP4 word burst at an offset of 0x3F8 so that the wrap happens exactly where an incrementing burst would carry into bit 10. It also runs an INCR8 burst and an undefined INCR burst that start a few bytes below the edge, so that the crossing flag rises on a known beat.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [2:0] {
    BK_SINGLE = 3'b000,
    BK_INCR   = 3'b001,
    BK_WRAP4  = 3'b010,
    BK_INCR4  = 3'b011,
    BK_WRAP8  = 3'b100,
    BK_INCR8  = 3'b101,
    BK_WRAP16 = 3'b110,
    BK_INCR16 = 3'b111
  } burst_kind_e;

  localparam int MAX_BEATS = 16;
  localparam int BEAT_W    = $clog2(MAX_BEATS);
  localparam int SIZE_W    = 2;
  localparam int BLOG_W    = 3;

  function automatic logic size_misaligned(input logic [2:0] size, input logic [1:0] low);
    case (size)
      3'b000:  return 1'b0;
      3'b001:  return low[0];
      3'b010:  return |low;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/burst_decode.sv
module burst_decode
  import burst_addr_pkg::*;
(
  input  logic [2:0]        kind,
  output logic              is_wrap,
  output logic              is_fixed,
  output logic [BEAT_W-1:0] last_idx,
  output logic [BLOG_W-1:0] beat_log2
);
  always_comb begin
    is_wrap   = 1'b0;
    is_fixed  = 1'b1;
    beat_log2 = '0;
    case (burst_kind_e'(kind))
      BK_SINGLE: beat_log2 = 3'd0;
      BK_INCR:   is_fixed  = 1'b0;
      BK_WRAP4:  begin is_wrap = 1'b1; beat_log2 = 3'd2; end
      BK_INCR4:  beat_log2 = 3'd2;
      BK_WRAP8:  begin is_wrap = 1'b1; beat_log2 = 3'd3; end
      BK_INCR8:  beat_log2 = 3'd3;
      BK_WRAP16: begin is_wrap = 1'b1; beat_log2 = 3'd4; end
      BK_INCR16: beat_log2 = 3'd4;
      default:   beat_log2 = 3'd0;
    endcase
    last_idx = BEAT_W'((32'd1 << beat_log2) - 32'd1);
  end
endmodule

// File: rtl/addr_step.sv
module addr_step
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [SIZE_W-1:0] size_log2,
  input  logic              is_wrap,
  input  logic [BLOG_W-1:0] beat_log2,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] wrap_mask;
  logic [3:0]        block_log2;

  always_comb begin
    incr       = ADDR_W'(1) << size_log2;
    sum        = cur_addr + incr;
    block_log2 = 4'(size_log2) + 4'(beat_log2);
    wrap_mask  = (ADDR_W'(1) << block_log2) - ADDR_W'(1);
    if (is_wrap) next_addr = (cur_addr & ~wrap_mask) | (sum & wrap_mask);
    else         next_addr = sum;
  end
endmodule

// File: rtl/beat_track.sv
module beat_track
  import burst_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat_idx <= '0;
    else if (clear) beat_idx <= '0;
    else if (adv)   beat_idx <= beat_idx + 1'b1;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_B = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        burst_kind,
  input  logic [2:0]        xfer_size,
  input  logic              step,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              active,
  output logic              last_beat,
  output logic              bdry_cross,
  output logic              align_err
);
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        kind_q;
  logic [SIZE_W-1:0] size_q;
  logic              active_q;
  logic              err_q;

  logic              is_wrap;
  logic              is_fixed;
  logic [BEAT_W-1:0] last_idx;
  logic [BLOG_W-1:0] beat_log2;
  logic [BEAT_W-1:0] beat_idx;
  logic [ADDR_W-1:0] next_addr;
  logic              step_ok;
  logic              load_bad;

  burst_decode u_dec (
    .kind      (kind_q),
    .is_wrap   (is_wrap),
    .is_fixed  (is_fixed),
    .last_idx  (last_idx),
    .beat_log2 (beat_log2)
  );

  addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr  (addr_q),
    .size_log2 (size_q),
    .is_wrap   (is_wrap),
    .beat_log2 (beat_log2),
    .next_addr (next_addr)
  );

  beat_track u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .adv      (step_ok),
    .beat_idx (beat_idx)
  );

  assign load_bad  = size_misaligned(xfer_size, start_addr[1:0]);
  assign step_ok   = step && active_q && !load;
  assign last_beat = active_q && is_fixed && (beat_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      kind_q   <= '0;
      size_q   <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (load) begin
      addr_q   <= start_addr;
      kind_q   <= burst_kind;
      size_q   <= xfer_size[SIZE_W-1:0];
      active_q <= !load_bad;
      err_q    <= load_bad;
    end else if (step_ok) begin
      if (last_beat) active_q <= 1'b0;
      else           addr_q   <= next_addr;
    end
  end

  assign beat_addr  = addr_q;
  assign active     = active_q;
  assign align_err  = err_q;
  assign bdry_cross = active_q && !is_wrap && !last_beat &&
                      (next_addr[ADDR_W-1:REGION_B] != addr_q[ADDR_W-1:REGION_B]);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W   = 32,
  parameter int REGION_B = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [ADDR_W-1:0] start_addr,
  input logic              step,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              active,
  input logic              last_beat,
  input logic              bdry_cross,
  input logic              align_err,
  input logic [2:0]        kind_q,
  input logic              is_wrap
);
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat_addr == $past(start_addr));

  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !active);

  p_end_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_beat && !load) |=> !active);

  p_incr_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind_q == 3'b001) |-> !last_beat);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> $stable(beat_addr));

  p_wrap_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_wrap && step && !load) |=>
      beat_addr[ADDR_W-1:REGION_B] == $past(beat_addr[ADDR_W-1:REGION_B]));

  p_cross_not_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bdry_cross |-> (!last_beat && !is_wrap));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .REGION_B(REGION_B)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .start_addr (start_addr),
  .step       (step),
  .beat_addr  (beat_addr),
  .active     (active),
  .last_beat  (last_beat),
  .bdry_cross (bdry_cross),
  .align_err  (align_err),
  .kind_q     (kind_q),
  .is_wrap    (is_wrap)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] start_addr = '0;
  logic [2:0]  burst_kind = '0;
  logic [2:0]  xfer_size = '0;
  logic        step = 1'b0;
  logic [31:0] beat_addr;
  logic        active, last_beat, bdry_cross, align_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .burst_kind(burst_kind), .xfer_size(xfer_size), .step(step),
    .beat_addr(beat_addr), .active(active), .last_beat(last_beat),
    .bdry_cross(bdry_cross), .align_err(align_err)
  );

  // {start address, burst kind, size}
  localparam logic [37:0] VEC [9] = '{
    {32'h0000_1000, 3'b000, 3'b010},
    {32'h0000_2004, 3'b011, 3'b010},
    {32'h0000_3008, 3'b010, 3'b010},
    {32'h0000_4006, 3'b100, 3'b001},
    {32'h0000_503D, 3'b110, 3'b000},
    {32'h0000_63F8, 3'b101, 3'b010},
    {32'h0000_7001, 3'b111, 3'b000},
    {32'h0000_83FE, 3'b001, 3'b001},
    {32'h0000_93F8, 3'b010, 3'b010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit kind_wrap(input logic [2:0] k);
    return (k == 3'b010) || (k == 3'b100) || (k == 3'b110);
  endfunction

  function automatic int kind_beats(input logic [2:0] k);
    case (k)
      3'b000: return 1;
      3'b010, 3'b011: return 4;
      3'b100, 3'b101: return 8;
      3'b110, 3'b111: return 16;
      default: return 6;
    endcase
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] a, input logic [2:0] k,
                                             input logic [2:0] s);
    int bytes = 1 << s;
    logic [31:0] blk;
    if (!kind_wrap(k)) return a + bytes;
    blk = 32'(kind_beats(k) * bytes);
    return (a / blk) * blk + ((a % blk) + bytes) % blk;
  endfunction

  task automatic do_load(input logic [31:0] a, input logic [2:0] k, input logic [2:0] s);
    @(negedge clk);
    load = 1'b1; start_addr = a; burst_kind = k; xfer_size = s;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulse_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic run_vec(input logic [37:0] v);
    logic [31:0] a = v[37:6];
    logic [2:0]  k = v[5:3];
    logic [2:0]  s = v[2:0];
    int n = kind_beats(k);
    bit fixed = (k != 3'b001);
    logic [31:0] ea = a;
    logic [31:0] nx;
    do_load(a, k, s);
    chk("R2 load addr", beat_addr, a);
    chk("R2 active after load", active, 1);
    for (int i = 0; i < n; i++) begin
      bit el = fixed && (i == n - 1);
      nx = model_next(ea, k, s);
      chk(kind_wrap(k) ? "R4 wrap addr" : "R3 incr addr", beat_addr, ea);
      chk(fixed ? "R5 last_beat" : "R7 no last", last_beat, el);
      chk("R8 bdry_cross", bdry_cross,
          !kind_wrap(k) && !el && (nx[31:10] != ea[31:10]));
      pulse_step();
      if (!el) ea = nx;
    end
    if (fixed) begin
      chk("R6 inactive after final", active, 0);
      chk("R6 addr holds final", beat_addr, ea);
      pulse_step();
      chk("R10 step idle ignored", beat_addr, ea);
    end else begin
      chk("R7 still active", active, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset addr", beat_addr, 0);
    chk("R1 reset active", active, 0);
    chk("R1 reset last", last_beat, 0);
    chk("R1 reset cross", bdry_cross, 0);
    chk("R1 reset err", align_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_step();
    chk("R10 step before load", beat_addr, 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // misaligned halfword
    do_load(32'h0000_0101, 3'b011, 3'b001);
    chk("R9 hw misalign err", align_err, 1);
    chk("R9 hw misalign inactive", active, 0);
    pulse_step();
    chk("R9 step blocked", beat_addr, 32'h0000_0101);
    // misaligned word
    do_load(32'h0000_0202, 3'b001, 3'b010);
    chk("R9 word misalign err", align_err, 1);
    // oversize
    do_load(32'h0000_0400, 3'b011, 3'b011);
    chk("R9 size too large", align_err, 1);
    chk("R9 size too large inactive", active, 0);
    // good load clears err
    do_load(32'h0000_0500, 3'b011, 3'b010);
    chk("R9 err cleared", align_err, 0);
    // load and step together: load wins
    @(negedge clk);
    load = 1'b1; step = 1'b1; start_addr = 32'h0000_0A00; burst_kind = 3'b011; xfer_size = 3'b010;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    chk("R2 load beats step", beat_addr, 32'h0000_0A00);
    chk("R5 not last at beat0", last_beat, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule